// File: doc/BRIEF.md
# Software-Refilled Address Translation Cache

This block caches page translations from virtual to physical addresses. It holds a small set of entries and compares all of them in parallel. Each entry stores a virtual page number and the physical page number it maps to. It also keeps a valid flag, a written-to (dirty) flag, a recently-used (reference) flag and a rights field. A lookup presents a full virtual address. One clock later the block returns the physical address, which is the translated page number joined to the unchanged page offset. Instead of the address, it can return a trap that carries the faulting virtual address.

A miss never reads memory. The block only raises a trap, and system software walks its own tables. Software then installs the mapping through a write port that names the target slot and supplies every field of the entry. Software picks the victim slot, so it chooses the replacement order. Two aids help with that choice. A clear command zeroes every reference flag at once, so software can sample which entries were used. A readback port shows the valid, dirty and reference state of any slot, so software knows whether a page must be written back before it is evicted.

Top module: `sw_tlb`

## Requirements
- R1: After reset every entry is invalid, and `res_valid`, `res_hit`, `res_miss_trap`, `res_prot_trap`, `res_paddr` and `res_fault_vaddr` are all zero.
- R2: A lookup that matches a valid entry and is not blocked by rights gives the following on the next cycle: `res_valid`=1, `res_hit`=1, and `res_paddr` equal to the entry's physical page number in the upper bits with the lookup's low OFF_W offset bits below it. Both trap outputs are 0 and `res_fault_vaddr` is 0.
- R3: A lookup that matches no valid entry gives the following on the next cycle: `res_miss_trap`=1, `res_hit`=0, `res_paddr`=0 and `res_fault_vaddr` equal to the looked-up address. An entry whose valid flag is 0 never matches, even when its page number is equal.
- R4: Any lookup that matches an entry sets that entry's reference flag. This includes a lookup that raises a protection trap. The flag is visible on `rd_ref` from the cycle after the lookup.
- R5: A write lookup (`lk_write`=1) that hits an entry whose rights bit 0 is 1 sets that entry's dirty flag. A read lookup leaves the dirty flag unchanged.
- R6: A write lookup that hits an entry whose rights bit 0 is 0 gives the following on the next cycle: `res_prot_trap`=1, `res_hit`=0, `res_paddr`=0 and `res_fault_vaddr` equal to the looked-up address. The entry's dirty flag is unchanged.
- R7: When `wr_en`=1, slot `wr_idx` takes `wr_vpn`, `wr_ppn`, `wr_rights`, `wr_valid`, `wr_dirty` and `wr_ref` at the clock edge. Lookups see the new entry from the next cycle, and `rd_valid`/`rd_dirty`/`rd_ref` at `rd_idx` return the stored flags combinationally.
- R8: A software write with `wr_valid`=1 clears the valid flag of every other slot that holds the same virtual page number. Later lookups of that page therefore return the new mapping.
- R9: `clr_ref`=1 zeroes every reference flag at the next edge. A lookup in the same cycle does not leave its flag set. A software write in the same cycle still stores its own `wr_ref` value in its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a store access |
| lk_vaddr | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Result of last cycle's lookup present |
| res_hit | output | 1 | Translation succeeded |
| res_paddr | output | 32 | Translated physical address |
| res_miss_trap | output | 1 | No valid entry matched |
| res_prot_trap | output | 1 | Store to an entry without write right |
| res_fault_vaddr | output | 32 | Address that trapped |
| wr_en | input | 1 | Software entry write |
| wr_idx | input | 4 | Slot to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_rights | input | 2 | Rights; bit 0 grants writes |
| wr_valid | input | 1 | Valid flag to store |
| wr_dirty | input | 1 | Dirty flag to store |
| wr_ref | input | 1 | Reference flag to store |
| clr_ref | input | 1 | Zero all reference flags |
| rd_idx | input | 4 | Slot to read back |
| rd_valid | output | 1 | Valid flag of slot rd_idx |
| rd_dirty | output | 1 | Dirty flag of slot rd_idx |
| rd_ref | output | 1 | Reference flag of slot rd_idx |

## Verification
Every lookup result appears on the result outputs exactly one edge after the lookup is presented. The bench therefore places the expected outcome in a queue when it drives a lookup. A monitor takes the next queued item whenever `res_valid` is sampled high, just after each rising edge, and flags any result that appears with nothing queued. Flag changes from lookups, software writes and the clear command land on the same edge. The bench reads them through the readback port at the falling edge that follows, before any further stimulus.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // width of the per-entry rights field
    localparam int RIGHTS_W = 2;
    // bit position inside the rights field that grants store accesses
    localparam int RIGHT_STORE_BIT = 0;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
    parameter int N    = 16,
    parameter int TAGW = 20
) (
    input  logic [TAGW-1:0]   key,
    input  logic [N-1:0]      live,
    input  logic [N*TAGW-1:0] tags,
    output logic [N-1:0]      match
);
    // one comparator per slot, all in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g*TAGW +: TAGW] == key);
    end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        // scan downward so the lowest requesting slot wins
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               lk_valid,
    input  logic                               lk_write,
    input  logic [VPN_W+OFF_W-1:0]             lk_vaddr,
    output logic                               res_valid,
    output logic                               res_hit,
    output logic [PPN_W+OFF_W-1:0]             res_paddr,
    output logic                               res_miss_trap,
    output logic                               res_prot_trap,
    output logic [VPN_W+OFF_W-1:0]             res_fault_vaddr,
    input  logic                               wr_en,
    input  logic [$clog2(ENTRIES)-1:0]         wr_idx,
    input  logic [VPN_W-1:0]                   wr_vpn,
    input  logic [PPN_W-1:0]                   wr_ppn,
    input  logic [tlb_pkg::RIGHTS_W-1:0]       wr_rights,
    input  logic                               wr_valid,
    input  logic                               wr_dirty,
    input  logic                               wr_ref,
    input  logic                               clr_ref,
    input  logic [$clog2(ENTRIES)-1:0]         rd_idx,
    output logic                               rd_valid,
    output logic                               rd_dirty,
    output logic                               rd_ref
);
    import tlb_pkg::*;

    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic                valid;
        logic                dirty;
        logic                refb;
        logic [RIGHTS_W-1:0] rights;
        logic [VPN_W-1:0]    vpn;
        logic [PPN_W-1:0]    ppn;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic                r_valid;
        logic                r_hit;
        logic [PA_W-1:0]     r_paddr;
        logic                r_miss;
        logic                r_prot;
        logic [VA_W-1:0]     r_fva;
    } state_t;

    state_t st_d, st_q;

    // flattened views of the slot array for the comparators
    logic [ENTRIES-1:0]       live_vec;
    logic [ENTRIES-1:0]       ref_vec;
    logic [ENTRIES*VPN_W-1:0] tag_flat;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            live_vec[i]                 = st_q.slot[i].valid;
            ref_vec[i]                  = st_q.slot[i].refb;
            tag_flat[i*VPN_W +: VPN_W]  = st_q.slot[i].vpn;
        end
    end

    logic [VPN_W-1:0]   lk_vpn;
    logic [OFF_W-1:0]   lk_off;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] dup_match;
    logic [IDX_W-1:0]   hit_idx;
    logic               hit_any;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    tlb_cam_match #(.N(ENTRIES), .TAGW(VPN_W)) u_lk_cmp (
        .key   (lk_vpn),
        .live  (live_vec),
        .tags  (tag_flat),
        .match (lk_match)
    );

    // second comparator bank finds stale copies of a page being installed
    tlb_cam_match #(.N(ENTRIES), .TAGW(VPN_W)) u_dup_cmp (
        .key   (wr_vpn),
        .live  (live_vec),
        .tags  (tag_flat),
        .match (dup_match)
    );

    tlb_prio_enc #(.N(ENTRIES), .IW(IDX_W)) u_enc (
        .req (lk_match),
        .idx (hit_idx),
        .any (hit_any)
    );

    logic store_ok;
    logic prot_fault;
    logic lk_hit;

    assign store_ok   = st_q.slot[hit_idx].rights[RIGHT_STORE_BIT];
    assign lk_hit     = lk_valid && hit_any;
    assign prot_fault = lk_hit && lk_write && !store_ok;

    always_comb begin
        st_d = st_q;

        // registered lookup result
        st_d.r_valid = lk_valid;
        st_d.r_hit   = lk_hit && !prot_fault;
        st_d.r_miss  = lk_valid && !hit_any;
        st_d.r_prot  = prot_fault;
        st_d.r_paddr = (lk_hit && !prot_fault) ? {st_q.slot[hit_idx].ppn, lk_off} : '0;
        st_d.r_fva   = ((lk_valid && !hit_any) || prot_fault) ? lk_vaddr : '0;

        // usage tracking from the lookup path
        if (lk_hit) begin
            st_d.slot[hit_idx].refb = 1'b1;
            if (lk_write && store_ok) begin
                st_d.slot[hit_idx].dirty = 1'b1;
            end
        end

        // periodic usage sampling overrides lookup marking
        if (clr_ref) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.slot[i].refb = 1'b0;
            end
        end

        // software install has the final say on its slot
        if (wr_en) begin
            if (wr_valid) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (dup_match[i] && (i != int'(wr_idx))) begin
                        st_d.slot[i].valid = 1'b0;
                    end
                end
            end
            st_d.slot[wr_idx].valid  = wr_valid;
            st_d.slot[wr_idx].dirty  = wr_dirty;
            st_d.slot[wr_idx].refb   = wr_ref;
            st_d.slot[wr_idx].rights = wr_rights;
            st_d.slot[wr_idx].vpn    = wr_vpn;
            st_d.slot[wr_idx].ppn    = wr_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid       = st_q.r_valid;
    assign res_hit         = st_q.r_hit;
    assign res_paddr       = st_q.r_paddr;
    assign res_miss_trap   = st_q.r_miss;
    assign res_prot_trap   = st_q.r_prot;
    assign res_fault_vaddr = st_q.r_fva;

    assign rd_valid = st_q.slot[rd_idx].valid;
    assign rd_dirty = st_q.slot[rd_idx].dirty;
    assign rd_ref   = st_q.slot[rd_idx].refb;

    // R8
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || (res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))));

    // R3
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss_trap |-> (!res_hit && !res_prot_trap && res_valid));

    // R6
    prot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_prot_trap || ($past(lk_write) && !res_hit)));

    // R9
    ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref && !wr_en) |=> (ref_vec == '0));

    // R1
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && !res_miss_trap && !res_prot_trap));
endmodule

// File: tb/sim_sw_tlb.sv
`timescale 1ns/1ps
module sim_sw_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        res_valid, res_hit, res_miss_trap, res_prot_trap;
    logic [31:0] res_paddr, res_fault_vaddr;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [1:0]  wr_rights = '0;
    logic        wr_valid = 1'b0, wr_dirty = 1'b0, wr_ref = 1'b0;
    logic        clr_ref = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic        rd_valid, rd_dirty, rd_ref;

    always #2 clk = ~clk;

    sw_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
        .res_miss_trap(res_miss_trap), .res_prot_trap(res_prot_trap),
        .res_fault_vaddr(res_fault_vaddr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_rights(wr_rights), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_ref(wr_ref), .clr_ref(clr_ref),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_ref(rd_ref)
    );

    typedef struct {
        logic [66:0] v;   // {hit, miss, prot, paddr, fault_vaddr}
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per result, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && res_valid) begin
            logic [66:0] act;
            act = {res_hit, res_miss_trap, res_prot_trap, res_paddr, res_fault_vaddr};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", act, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(act == e.v, e.tag, act, e.v);
            end
        end
    end

    task automatic lookup(input logic [31:0] va, input bit wr, input bit clr,
                          input bit eh, input bit em, input bit ep,
                          input logic [31:0] epa, input string tag);
        exp_t e;
        e.v   = {eh, em, ep, epa, ((em || ep) ? va : 32'h0)};
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = va; clr_ref = clr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0; clr_ref = 1'b0;
    endtask

    task automatic install(input logic [3:0] idx, input logic [19:0] vpn, input logic [19:0] ppn,
                           input logic [1:0] rights, input bit v, input bit d, input bit r, input bit clr);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn;
        wr_rights = rights; wr_valid = v; wr_dirty = d; wr_ref = r; clr_ref = clr;
        @(negedge clk);
        wr_en = 1'b0; clr_ref = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] idx, input bit v, input bit d, input bit r, input string tag);
        rd_idx = idx;
        #1;
        check({rd_valid, rd_dirty, rd_ref} == {v, d, r}, tag,
              67'({rd_valid, rd_dirty, rd_ref}), 67'({v, d, r}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({res_valid, res_hit, res_miss_trap, res_prot_trap, res_paddr, res_fault_vaddr} == '0,
              "R1 results after reset",
              67'({res_valid, res_hit, res_miss_trap, res_prot_trap}), '0);
        rd_chk(4'd0, 0, 0, 0, "R1 slot0 empty");
        rd_chk(4'd15, 0, 0, 0, "R1 slot15 empty");

        // R3 miss on empty buffer
        lookup(32'h12345678, 0, 0, 0, 1, 0, 32'h0, "R3 miss empty");

        // R7 install and readback
        install(4'd3, 20'h12345, 20'hABCDE, 2'b01, 1, 0, 0, 0);
        rd_chk(4'd3, 1, 0, 0, "R7 installed flags");

        // R2 hit; R4 reference set; R5 read leaves dirty
        lookup(32'h12345678, 0, 0, 1, 0, 0, 32'hABCDE678, "R2 read hit");
        rd_chk(4'd3, 1, 0, 1, "R4 R5 ref set, clean after read");
        lookup(32'h12345ABC, 1, 0, 1, 0, 0, 32'hABCDEABC, "R2 write hit");
        rd_chk(4'd3, 1, 1, 1, "R5 dirty after write");

        // R6 store to entry without write right
        install(4'd7, 20'h00042, 20'h00777, 2'b10, 1, 0, 0, 0);
        lookup(32'h00042FFF, 1, 0, 0, 0, 1, 32'h0, "R6 protection trap");
        rd_chk(4'd7, 1, 0, 1, "R6 dirty kept, R4 ref set");
        lookup(32'h00042010, 0, 0, 1, 0, 0, 32'h00777010, "R6 read allowed");

        // R9 clear with concurrent lookup
        lookup(32'h12345000, 0, 1, 1, 0, 0, 32'hABCDE000, "R9 lookup during clear");
        rd_chk(4'd3, 1, 1, 0, "R9 ref cleared despite lookup");
        rd_chk(4'd7, 1, 0, 0, "R9 other ref cleared");
        // R9 clear with concurrent install keeps written ref
        install(4'd9, 20'h0BEEF, 20'h0CAFE, 2'b01, 1, 0, 1, 1);
        rd_chk(4'd9, 1, 0, 1, "R9 install ref survives clear");

        // R8 duplicate page replaces older copy
        install(4'd10, 20'h12345, 20'h55555, 2'b01, 1, 0, 0, 0);
        rd_chk(4'd3, 0, 1, 0, "R8 old copy invalidated");
        rd_chk(4'd10, 1, 0, 0, "R8 new copy valid");
        lookup(32'h12345001, 0, 0, 1, 0, 0, 32'h55555001, "R8 new mapping used");

        // R3 invalid slot with matching page does not hit
        install(4'd7, 20'h00042, 20'h00777, 2'b01, 0, 0, 0, 0);
        lookup(32'h00042123, 0, 0, 0, 1, 0, 32'h0, "R3 invalid slot ignored");

        // R2 boundary slots and addresses
        install(4'd15, 20'hFFFFF, 20'h00001, 2'b01, 1, 0, 0, 0);
        install(4'd0, 20'h00000, 20'hFFFFF, 2'b01, 1, 0, 0, 0);
        lookup(32'hFFFFFFFF, 1, 0, 1, 0, 0, 32'h00001FFF, "R2 top slot");
        lookup(32'h00000000, 0, 0, 1, 0, 0, 32'hFFFFF000, "R2 bottom slot");
        rd_chk(4'd15, 1, 1, 1, "R5 top slot dirty");

        // R7 overwrite a slot with a new page
        install(4'd15, 20'h00ABC, 20'h00DEF, 2'b01, 1, 0, 0, 0);
        lookup(32'hFFFFF004, 0, 0, 0, 1, 0, 32'h0, "R7 old page gone");
        lookup(32'h00ABC004, 0, 0, 1, 0, 0, 32'h00DEF004, "R7 new page hit");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", 67'(exp_q.size()), '0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule